// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Reset Float Override

This block is the test access port for a device with a small group of bidirectional bus pins. A serial test clock, a mode-select input and a data input drive a sixteen-state controller. Through that controller a tester loads an eight-bit instruction and then scans one of three data paths. The paths are a one-bit bypass stage, a 32-bit identification word, and a chain of boundary cells that sits between the functional core and the pads. Depending on the instruction, the pads either follow the core or take their level and enable from latches that the tester has loaded.

The device's own active-low system reset is not under test control. While it is low, every bus pin output enable is forced off, whatever the instruction or the boundary latches hold. The block therefore behaves as a fully standard test port only while system reset is held high. A tester that asserts system reset during a boundary test must expect floating outputs on the bus pins.

Top module: `scan_test_port`

## Requirements
- R1: The controller advances one of the sixteen standard states on each rising test-clock edge. Five consecutive rising edges with the mode input high reach the reset state from any state.
- R2: The reset state, or a low test-reset input when `HAS_TRST` is 1, makes the identification opcode (0x02) the active instruction. The pads then follow the core.
- R3: On entry to instruction capture, the instruction shift stage loads 0x01. It shifts least significant bit first, with the data input entering at the most significant bit. The shifted value becomes active on the falling edge in the instruction-update state.
- R4: Opcodes are 0x00 external test, 0x01 sample/preload, 0x02 identification, 0x03 clamp, 0x04 float and 0xFF bypass. Every other code behaves as bypass.
- R5: The bypass path is one stage that captures 0, so scanned data emerges delayed by one clock behind a leading 0.
- R6: The identification path is 32 bits and captures `ID_CODE` with bit 0 forced to 1. It shifts out least significant bit first.
- R7: The boundary chain is 3*NPIN cells. From the output end it holds pin inputs in bits [NPIN-1:0], core data in [2NPIN-1:NPIN] and core enables in [3NPIN-1:2NPIN], and it captures those values. The data and enable cells reach their update latches on the falling edge in the data-update state, and only under external test or sample/preload.
- R8: Under sample/preload, identification and bypass, `pin_out` and `pin_oe` equal `core_out` and `core_oe`.
- R9: Under external test and clamp, `pin_out` and `pin_oe` come from the data and enable update latches.
- R10: Under the float opcode, every `pin_oe` bit is 0.
- R11: While `sys_rst_n` is low, every `pin_oe` bit is 0 regardless of instruction or latches. With it high, R8 to R10 apply unchanged.
- R12: `tdo` changes on falling test-clock edges. `tdo_oe` is 1 only while the controller is in the instruction or data shift state.
- R13: `core_in` always equals `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (used when HAS_TRST=1) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Drive enable for tdo |
| sys_rst_n | input | 1 | Device system reset, active low; floats bus pins |
| core_out | input | NPIN | Functional output data from the core |
| core_oe | input | NPIN | Functional output enables from the core |
| core_in | output | NPIN | Pad input values passed to the core |
| pin_in | input | NPIN | Values seen at the pads |
| pin_out | output | NPIN | Data driven toward the pads |
| pin_oe | output | NPIN | Output enables toward the pads |

## Verification
The bench builds the block with NPIN=4, HAS_TRST=1 and an even `ID_CODE` (0x4B2E6A10). The identification scan can therefore only return 0x4B2E6A11 if bit 0 is really forced high. With four pins, the 12-cell chain is short enough that the bench can preload and capture distinct patterns for data, enables and inputs, and can tell a misplaced field apart. The test reset input lets the bench return the active instruction to identification in the middle of a float test.

// File: rtl/stp_pkg.sv
package stp_pkg;

  localparam int OPW = 8;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] { PATH_BYP, PATH_ID, PATH_CELLS } dr_path_e;

  localparam logic [OPW-1:0] OP_EXTEST = 8'h00;
  localparam logic [OPW-1:0] OP_SAMPLE = 8'h01;
  localparam logic [OPW-1:0] OP_IDENT  = 8'h02;
  localparam logic [OPW-1:0] OP_CLAMP  = 8'h03;
  localparam logic [OPW-1:0] OP_FLOAT  = 8'h04;
  localparam logic [OPW-1:0] OP_BYPASS = 8'hFF;
  localparam logic [OPW-1:0] IR_CAPTURE = 8'h01;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      default:   return tms ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_path_e op_path(input logic [OPW-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: return PATH_CELLS;
      OP_IDENT:             return PATH_ID;
      default:              return PATH_BYP;
    endcase
  endfunction

  function automatic logic op_uses_latches(input logic [OPW-1:0] op);
    return (op == OP_EXTEST) || (op == OP_CLAMP);
  endfunction

  function automatic logic op_floats(input logic [OPW-1:0] op);
    return op == OP_FLOAT;
  endfunction

endpackage

// File: rtl/stp_tap_fsm.sv
module stp_tap_fsm
  import stp_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e st,
  output logic       in_reset,
  output logic       cap_ir,
  output logic       sh_ir,
  output logic       upd_ir,
  output logic       cap_dr,
  output logic       sh_dr,
  output logic       upd_dr
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= ST_RESET;
    else        st <= tap_next(st, tms);
  end

  assign in_reset = (st == ST_RESET);
  assign cap_ir   = (st == ST_CAP_IR);
  assign sh_ir    = (st == ST_SH_IR);
  assign upd_ir   = (st == ST_UPD_IR);
  assign cap_dr   = (st == ST_CAP_DR);
  assign sh_dr    = (st == ST_SH_DR);
  assign upd_dr   = (st == ST_UPD_DR);

  // run of consecutive high mode samples, saturating at 5
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        hi_run <= 3'd0;
    else if (!tms)     hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  assert_five_high_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run == 3'd5) |-> (st == ST_RESET));

endmodule

// File: rtl/stp_instr_reg.sv
module stp_instr_reg
  import stp_pkg::*;
#(
  parameter int IRW = OPW,
  parameter logic [IRW-1:0] RESET_OP = IRW'(OP_IDENT),
  parameter logic [IRW-1:0] CAP_VAL  = IRW'(IR_CAPTURE)
) (
  input  logic           tck,
  input  logic           rst_n,
  input  logic           tdi,
  input  logic           in_reset,
  input  logic           cap,
  input  logic           sh,
  input  logic           upd,
  output logic           so,
  output logic [IRW-1:0] op
);

  logic [IRW-1:0] sr;

  always_ff @(posedge tck) begin
    if (cap)     sr <= CAP_VAL;
    else if (sh) sr <= {tdi, sr[IRW-1:1]};
  end

  assign so = sr[0];

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)        op <= RESET_OP;
    else if (in_reset) op <= RESET_OP;
    else if (upd)      op <= sr;
  end

  assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!rst_n)
    cap |=> (sr[1:0] == 2'b01));

  assert_reset_loads_ident_R2: assert property (@(posedge tck) disable iff (!rst_n)
    in_reset |=> (op == RESET_OP));

endmodule

// File: rtl/stp_cell_chain.sv
module stp_cell_chain #(
  parameter int NPIN = 4,
  localparam int CW = 3 * NPIN
) (
  input  logic            tck,
  input  logic            tdi,
  input  logic            cap,
  input  logic            sh,
  input  logic            upd,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic            so,
  output logic [NPIN-1:0] lat_out,
  output logic [NPIN-1:0] lat_oe
);

  logic [CW-1:0]     sr;
  logic [2*NPIN-1:0] lat;

  always_ff @(posedge tck) begin
    if (cap)     sr <= {core_oe, core_out, pin_in};
    else if (sh) sr <= {tdi, sr[CW-1:1]};
  end

  always_ff @(negedge tck) begin
    if (upd) lat <= sr[CW-1:NPIN];
  end

  assign so      = sr[0];
  assign lat_out = lat[NPIN-1:0];
  assign lat_oe  = lat[2*NPIN-1:NPIN];

endmodule

// File: rtl/stp_pin_mux.sv
module stp_pin_mux #(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            sys_rst_n,
  input  logic            use_latches,
  input  logic            float_all,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  input  logic [NPIN-1:0] lat_out,
  input  logic [NPIN-1:0] lat_oe,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);

  logic [NPIN-1:0] sel_oe;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_out[i] = use_latches ? lat_out[i] : core_out[i];
    assign sel_oe[i]  = float_all ? 1'b0 : (use_latches ? lat_oe[i] : core_oe[i]);
    assign pin_oe[i]  = sel_oe[i] & sys_rst_n;
  end

  assert_sysrst_floats_R11: assert property (@(posedge tck) disable iff (!rst_n)
    !sys_rst_n |-> (pin_oe == '0));

  assert_latch_drive_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (use_latches && !float_all) |-> (pin_out == lat_out));

endmodule

// File: rtl/scan_test_port.sv
module scan_test_port
  import stp_pkg::*;
#(
  parameter int          NPIN     = 4,
  parameter bit          HAS_TRST = 1'b1,
  parameter int          IDW      = 32,
  parameter logic [31:0] ID_CODE  = 32'h4B2E_6A11
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic            sys_rst_n,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic [NPIN-1:0] core_in,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);

  localparam logic [IDW-1:0] ID_CAP = IDW'(ID_CODE) | IDW'(1);

  logic tap_rst_n;
  if (HAS_TRST) begin : g_trst
    assign tap_rst_n = trst_n;
  end else begin : g_no_trst
    assign tap_rst_n = 1'b1;
  end

  tap_state_e st;
  logic in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;

  stp_tap_fsm u_fsm (
    .tck(tck), .rst_n(tap_rst_n), .tms(tms), .st(st), .in_reset(in_reset),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
  );

  logic           ir_so;
  logic [OPW-1:0] op;

  stp_instr_reg #(.IRW(OPW)) u_ir (
    .tck(tck), .rst_n(tap_rst_n), .tdi(tdi), .in_reset(in_reset),
    .cap(cap_ir), .sh(sh_ir), .upd(upd_ir), .so(ir_so), .op(op)
  );

  dr_path_e path;
  logic     sel_cells, sel_id, sel_byp;
  assign path      = op_path(op);
  assign sel_cells = (path == PATH_CELLS);
  assign sel_id    = (path == PATH_ID);
  assign sel_byp   = (path == PATH_BYP);

  // boundary cells
  logic            cell_so;
  logic [NPIN-1:0] lat_out, lat_oe;

  stp_cell_chain #(.NPIN(NPIN)) u_cells (
    .tck(tck), .tdi(tdi),
    .cap(cap_dr && sel_cells), .sh(sh_dr && sel_cells), .upd(upd_dr && sel_cells),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .so(cell_so), .lat_out(lat_out), .lat_oe(lat_oe)
  );

  // identification and bypass paths
  logic [IDW-1:0] id_sr;
  logic           byp_q;

  always_ff @(posedge tck) begin
    if (cap_dr && sel_id)     id_sr <= ID_CAP;
    else if (sh_dr && sel_id) id_sr <= {tdi, id_sr[IDW-1:1]};
  end

  always_ff @(posedge tck) begin
    if (cap_dr && sel_byp)     byp_q <= 1'b0;
    else if (sh_dr && sel_byp) byp_q <= tdi;
  end

  // serial output, launched on the falling edge
  logic dr_so;
  always_comb begin
    case (path)
      PATH_CELLS: dr_so = cell_so;
      PATH_ID:    dr_so = id_sr[0];
      default:    dr_so = byp_q;
    endcase
  end

  always_ff @(negedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir || sh_dr;
      if (sh_ir)      tdo <= ir_so;
      else if (sh_dr) tdo <= dr_so;
    end
  end

  stp_pin_mux #(.NPIN(NPIN)) u_mux (
    .tck(tck), .rst_n(tap_rst_n), .sys_rst_n(sys_rst_n),
    .use_latches(op_uses_latches(op)), .float_all(op_floats(op)),
    .core_out(core_out), .core_oe(core_oe), .lat_out(lat_out), .lat_oe(lat_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign core_in = pin_in;

  assert_tdo_oe_shift_only_R12: assert property (@(posedge tck) disable iff (!tap_rst_n)
    tdo_oe |-> (st == ST_SH_IR || st == ST_SH_DR));

  assert_float_opcode_R10: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (op == OP_FLOAT) |-> (pin_oe == '0));

  assert_bypass_captures_zero_R5: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (cap_dr && sel_byp) |=> (byp_q == 1'b0));

  assert_id_lsb_set_R6: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (cap_dr && sel_id) |=> id_sr[0]);

  assert_functional_follow_R8: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (sys_rst_n && (op == OP_SAMPLE || op == OP_IDENT || op == OP_BYPASS))
      |-> (pin_out == core_out && pin_oe == core_oe));

endmodule

// File: tb/sim_scan_test_port.sv
`timescale 1ns/1ps
module sim_scan_test_port;

  localparam int NP = 4;
  localparam logic [31:0] IDV = 32'h4B2E_6A10;
  localparam logic [31:0] ID_EXP = 32'h4B2E_6A11;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, sys_rst_n = 1'b1;
  logic [NP-1:0] core_out = '0, core_oe = '0, pin_in = '0;
  logic tdo, tdo_oe;
  logic [NP-1:0] core_in, pin_out, pin_oe;

  scan_test_port #(.NPIN(NP), .HAS_TRST(1'b1), .ID_CODE(IDV)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .sys_rst_n(sys_rst_n), .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct { string tag; logic [31:0] v; } item_t;
  item_t exp_q[$];
  logic [31:0] obs_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // driver side: record expectation and observation
  task automatic expect_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.v = exp;
    exp_q.push_back(it);
    obs_q.push_back(act);
  endtask

  // monitor: pops and compares
  task automatic drain();
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = exp_q.pop_front();
      a = obs_q.pop_front();
      checks++;
      if (a !== it.v) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, a, it.v);
      end
    end
  endtask

  initial forever begin
    @(negedge tck);
    drain();
  end

  task automatic tick(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [31:0] din,
                      output logic [31:0] dout, output bit oe_ok);
    dout = '0;
    oe_ok = 1'b1;
    tick(1'b1, 1'b0);
    if (is_ir) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      if (tdo_oe !== 1'b1) oe_ok = 1'b0;
      tms = (i == n - 1);
      tdi = din[i];
      @(posedge tck);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [7:0] op);
    logic [31:0] d;
    bit ok;
    scan(1'b1, 8, {24'h0, op}, d, ok);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    bit ok;
    core_out = 4'b0101; core_oe = 4'b0011; pin_in = 4'b1001;
    repeat (3) @(posedge tck);
    @(negedge tck); trst_n = 1'b1;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge tck); #1;

    // reset state
    expect_val("R12 tdo_oe idle", {31'h0, tdo_oe}, 32'h0);
    expect_val("R2 R8 pin_out after reset", {28'h0, pin_out}, {28'h0, core_out});
    expect_val("R2 R8 pin_oe after reset", {28'h0, pin_oe}, {28'h0, core_oe});
    expect_val("R13 core_in", {28'h0, core_in}, {28'h0, pin_in});

    // instruction capture value, identification scan
    scan(1'b1, 8, 32'h02, d, ok);
    expect_val("R3 IR capture 0x01", d, 32'h01);
    expect_val("R12 tdo_oe in shift", {31'h0, ok}, 32'h1);
    expect_val("R12 tdo_oe after shift", {31'h0, tdo_oe}, 32'h0);
    scan(1'b0, 32, 32'h0, d, ok);
    expect_val("R6 R2 id scan", d, ID_EXP);

    // bypass
    load_ir(8'hFF);
    scan(1'b0, 8, 32'hB2, d, ok);
    expect_val("R5 bypass delay", d, 32'h64);
    load_ir(8'hA5);
    scan(1'b0, 8, 32'h3C, d, ok);
    expect_val("R4 unknown opcode bypass", d, 32'h78);

    // sample/preload
    pin_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b1100;
    load_ir(8'h01);
    scan(1'b0, 12, 32'hF90, d, ok);
    expect_val("R7 sample capture", d, 32'hC6A);
    expect_val("R8 sample pin_out", {28'h0, pin_out}, 32'h6);
    expect_val("R8 sample pin_oe", {28'h0, pin_oe}, 32'hC);

    // external test
    load_ir(8'h00);
    expect_val("R9 extest pin_out", {28'h0, pin_out}, 32'h9);
    expect_val("R9 extest pin_oe", {28'h0, pin_oe}, 32'hF);
    sys_rst_n = 1'b0; #2;
    expect_val("R11 sysrst floats", {28'h0, pin_oe}, 32'h0);
    sys_rst_n = 1'b1; #2;
    expect_val("R11 sysrst released", {28'h0, pin_oe}, 32'hF);
    scan(1'b0, 12, 32'h530, d, ok);
    expect_val("R7 extest capture", d, 32'hC6A);
    expect_val("R9 R7 extest new pin_out", {28'h0, pin_out}, 32'h3);
    expect_val("R9 R7 extest new pin_oe", {28'h0, pin_oe}, 32'h5);

    // clamp: pins held, bypass path, latches untouched by update
    load_ir(8'h03);
    scan(1'b0, 4, 32'hF, d, ok);
    expect_val("R4 R5 clamp bypass", d, 32'hE);
    expect_val("R9 R7 clamp pin_out held", {28'h0, pin_out}, 32'h3);
    expect_val("R9 R7 clamp pin_oe held", {28'h0, pin_oe}, 32'h5);

    // float
    load_ir(8'h04);
    expect_val("R10 float pin_oe", {28'h0, pin_oe}, 32'h0);
    scan(1'b0, 4, 32'h1, d, ok);
    expect_val("R10 R5 float bypass", d, 32'h2);

    // five TMS-high from shift-DR
    load_ir(8'hFF);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge tck); #1;
    expect_val("R1 R2 pins follow core", {24'h0, pin_oe, pin_out}, {24'h0, core_oe, core_out});
    scan(1'b0, 32, 32'h0, d, ok);
    expect_val("R1 id after five high", d, ID_EXP);

    // test reset during float
    load_ir(8'h04);
    expect_val("R10 float again", {28'h0, pin_oe}, 32'h0);
    @(negedge tck); trst_n = 1'b0; #2;
    expect_val("R2 trst restores pins", {28'h0, pin_oe}, {28'h0, core_oe});
    @(negedge tck); trst_n = 1'b1;
    tick(1'b0, 1'b0);
    scan(1'b0, 32, 32'h0, d, ok);
    expect_val("R2 id after trst", d, ID_EXP);
    expect_val("R13 core_in late", {28'h0, core_in}, {28'h0, pin_in});

    repeat (4) @(posedge tck);
    finish_run();
  end

endmodule